// File: doc/BRIEF.md
# GPIO Bank Register File with Masked-Write Aliases

This block holds the pin control state for one GPIO bank of four ports, each eight pins wide. A word-addressed register bus reaches three writable registers per port: a configure word that hands the pin to the GPIO function, a drive-enable word and an output-value word. A fourth, read-only word per port returns the pad levels after a two-stage synchronizer. The pads see a drive enable and a drive value from these registers.

Each writable register has a second address, the masked alias, located at a parameter offset (`UPPER_OFF`) above the plain one. A write there carries a pin-select byte in bits [15:8] and new pin values in bits [7:0]. Only the selected pins change, so two software agents can own different pins of one port without a read-modify-write race.

The interrupt groups share this address window but live in a neighbouring block. This block decodes them, raises `irq_sel` for any access to them, and passes `irq_rdata` back on reads. It changes no state of its own for those accesses. Register fields and pin order use bit i of a port word for pin i of that port, and pad bit index `port*8 + pin`.

Top module: `gpb_bank_regs`

## Requirements
- R1: After reset every configure, drive-enable and output-value register reads 0, and `pad_oe` and `pad_out` are all 0.
- R2: A write to a plain address replaces all eight bits of the target register. The group offsets are 0x00 for configure, 0x10 for drive enable and 0x20 for output value, plus port×4. A read returns the register in bits [7:0] and 0 in bits [31:8].
- R3: A write to `UPPER_OFF` plus the same offset is a masked write. It leaves the register as (old AND NOT sel) OR (val AND sel), where sel = wdata[15:8] and val = wdata[7:0].
- R4: Pad bit p*8+i has `pad_oe` = cfg[i] AND oe[i] and `pad_out` = cfg[i] AND out[i] of port p.
- R5: Reading offset 0x30 + port×4 returns the pad levels of that port. A change on `pad_in` is not visible after the first rising edge and is visible after the second.
- R6: Writes to the input address, plain (0x30) or alias (`UPPER_OFF`+0x30), change no register and no pad output.
- R7: Plain offsets 0x40–0x7F and alias offsets 0x40–0x6F assert `irq_sel`, and a read there returns `irq_rdata`. A write there changes no local register. Alias offsets 0x70–0x7F are unmapped.
- R8: Any address outside the plain window (0x000–0x07F) and the alias window reads 0 with `irq_sel` low, and writes to it are ignored.
- R9: A write to one port leaves the registers of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address inside the bank, bits [1:0] ignored |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_sel | output | 1 | Current address falls in the interrupt groups |
| irq_rdata | input | 32 | Read data supplied by the interrupt block |
| pad_in | input | PORTS*8 | Raw pad levels |
| pad_out | output | PORTS*8 | Pad drive values |
| pad_oe | output | PORTS*8 | Pad drive enables |

## Verification
A wrong bit in any control register shows at the ports through two paths. It appears on the next read of that register, and on `pad_oe` or `pad_out` in the cycle after the bad write. The bench therefore compares the whole register set and both pad vectors against its arithmetic model after each write. A masked write that corrupts unselected pins is caught in the same pass, because every selection byte is swept for every register of every port. A synchronizer of the wrong depth shows up as a one-cycle shift in when a new pad level first appears on read.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int PIN_W        = 8;   // pins per port, fixed by the masked word format
    localparam int PORT_FIELD_W = 2;   // address bits [3:2]
    localparam int WINDOW_BYTES = 128; // eight groups of 16 bytes
    localparam int NUM_CTRL     = 3;   // configure, drive enable, output value

    typedef enum logic [2:0] {
        GRP_CFG  = 3'd0,
        GRP_OE   = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_IN   = 3'd3,
        GRP_ISTA = 3'd4,
        GRP_IENB = 3'd5,
        GRP_ILVL = 3'd6,
        GRP_ICLR = 3'd7
    } grp_e;

    typedef struct packed {
        logic [PIN_W-1:0] sel;
        logic [PIN_W-1:0] val;
    } mword_t;

    typedef struct packed {
        logic                    hit;
        logic                    masked;
        grp_e                    grp;
        logic [PORT_FIELD_W-1:0] port;
    } dec_t;

    function automatic logic [PIN_W-1:0] merge_bits(input logic [PIN_W-1:0] old,
                                                    input mword_t w);
        return (old & ~w.sel) | (w.val & w.sel);
    endfunction

    function automatic logic has_alias(input grp_e g);
        return !(g == GRP_IN || g == GRP_ICLR);
    endfunction

endpackage

// File: rtl/gpb_addr_dec.sv
module gpb_addr_dec
    import gpb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int UPPER_OFF = 'h800,
    parameter int PORTS     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] OFFS_MASK   = ADDR_W'(WINDOW_BYTES - 1);
    localparam logic [ADDR_W-1:0] REGION_MASK = ~OFFS_MASK;
    localparam logic [ADDR_W-1:0] ALIAS_BASE  = ADDR_W'(UPPER_OFF);

    logic [ADDR_W-1:0] region;
    logic              in_plain;
    logic              in_alias;
    logic              port_ok;
    grp_e              grp;

    always_comb begin
        region   = addr & REGION_MASK;
        in_plain = (region == '0);
        in_alias = (region == ALIAS_BASE);
        grp      = grp_e'(addr[6:4]);
        port_ok  = (int'(addr[3:2]) < PORTS);

        dec.grp    = grp;
        dec.port   = addr[3:2];
        dec.masked = in_alias;
        dec.hit    = port_ok && (in_plain || (in_alias && has_alias(grp)));
    end
endmodule

// File: rtl/gpb_mask_reg.sv
module gpb_mask_reg
    import gpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             masked,
    input  mword_t           wword,
    output logic [PIN_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= masked ? merge_bits(q, wword) : wword.val;
        end
    end

    // R2: a plain write lands all eight bits
    a_r2_plain_replaces: assert property (@(posedge clk) disable iff (rst)
        we && !masked |=> q == $past(wword.val));

    // R3: unselected pins keep their old value
    a_r3_unselected_kept: assert property (@(posedge clk) disable iff (rst)
        we && masked |=> (q & ~$past(wword.sel)) == ($past(q) & ~$past(wword.sel)));

    // R3: selected pins take the new value
    a_r3_selected_taken: assert property (@(posedge clk) disable iff (rst)
        we && masked |=> (q & $past(wword.sel)) == ($past(wword.val) & $past(wword.sel)));

    // R9: no strobe, no change
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
        end
    end

    assign dout = stage2;

    // R5: output equals the input of two edges earlier
    a_r5_two_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(rst, 2) |-> dout == $past(din, 2));
endmodule

// File: rtl/gpb_bank_regs.sv
module gpb_bank_regs
    import gpb_pkg::*;
#(
    parameter int PORTS     = 4,
    parameter int ADDR_W    = 12,
    parameter int UPPER_OFF = 'h800,
    parameter int DATA_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wen,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   irq_sel,
    input  logic [DATA_W-1:0]      irq_rdata,
    input  logic [PORTS*PIN_W-1:0] pad_in,
    output logic [PORTS*PIN_W-1:0] pad_out,
    output logic [PORTS*PIN_W-1:0] pad_oe
);
    localparam int PADS = PORTS * PIN_W;

    dec_t             dec;
    mword_t           wword;
    logic [PADS-1:0]  in_sync;
    logic [PIN_W-1:0] ctrl_q [PORTS][NUM_CTRL];
    logic [PIN_W-1:0] rd_byte;

    assign wword = mword_t'(bus_wdata[2*PIN_W-1:0]);

    gpb_addr_dec #(
        .ADDR_W   (ADDR_W),
        .UPPER_OFF(UPPER_OFF),
        .PORTS    (PORTS)
    ) u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    gpb_sync #(.WIDTH(PADS)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pad_in),
        .dout(in_sync)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        for (genvar r = 0; r < NUM_CTRL; r++) begin : g_reg
            logic we;
            assign we = bus_wen && dec.hit && (dec.grp == grp_e'(r))
                        && (int'(dec.port) == p);
            gpb_mask_reg u_reg (
                .clk   (clk),
                .rst   (rst),
                .we    (we),
                .masked(dec.masked),
                .wword (wword),
                .q     (ctrl_q[p][r])
            );
        end
        assign pad_oe [p*PIN_W +: PIN_W] = ctrl_q[p][GRP_CFG] & ctrl_q[p][GRP_OE];
        assign pad_out[p*PIN_W +: PIN_W] = ctrl_q[p][GRP_CFG] & ctrl_q[p][GRP_OUT];
    end

    assign irq_sel = dec.hit && dec.grp[2];

    always_comb begin
        rd_byte = '0;
        case (dec.grp)
            GRP_CFG, GRP_OE, GRP_OUT: rd_byte = ctrl_q[dec.port][dec.grp[1:0]];
            GRP_IN:                   rd_byte = in_sync[dec.port*PIN_W +: PIN_W];
            default:                  rd_byte = '0;
        endcase
        if (!dec.hit)     bus_rdata = '0;
        else if (irq_sel) bus_rdata = irq_rdata;
        else              bus_rdata = DATA_W'(rd_byte);
    end

    // R1: the cycle after reset, no pad is driven
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pad_oe == '0 && pad_out == '0);

    // R8: without a write strobe the pad controls hold
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_wen |=> $stable(pad_oe) && $stable(pad_out));

    // R7: accesses to interrupt groups leave local pad controls alone
    a_r7_irq_no_effect: assert property (@(posedge clk) disable iff (rst)
        bus_wen && irq_sel |=> $stable(pad_oe) && $stable(pad_out));
endmodule

// File: tb/gpb_bank_regs_bench.sv
module gpb_bank_regs_bench;
    localparam int PORTS = 4;
    localparam int AW    = 12;
    localparam int UOFF  = 'h800;
    localparam int PADS  = PORTS * 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wen = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_sel;
    logic [31:0]     irq_rdata = '0;
    logic [PADS-1:0] pad_in = '0;
    logic [PADS-1:0] pad_out;
    logic [PADS-1:0] pad_oe;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_reg [PORTS][3];

    always #4 clk = ~clk;

    gpb_bank_regs #(.PORTS(PORTS), .ADDR_W(AW), .UPPER_OFF(UOFF)) u_gpb_bank_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_sel(irq_sel),
        .irq_rdata(irq_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr  = AW'(addr);
        bus_wdata = data;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        bus_addr = AW'(addr);
        #1;
        data = bus_rdata;
    endtask

    function automatic int reg_addr(input int grp, input int port);
        return grp * 16 + port * 4;
    endfunction

    task automatic model_clear();
        for (int p = 0; p < PORTS; p++)
            for (int r = 0; r < 3; r++) m_reg[p][r] = 8'h00;
    endtask

    task automatic check_pads(input string req);
        logic [PADS-1:0] e_oe, e_out;
        for (int p = 0; p < PORTS; p++) begin
            e_oe [p*8 +: 8] = m_reg[p][0] & m_reg[p][1];
            e_out[p*8 +: 8] = m_reg[p][0] & m_reg[p][2];
        end
        check({req, " pad_oe"},  32'(pad_oe),  32'(e_oe));
        check({req, " pad_out"}, 32'(pad_out), 32'(e_out));
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        for (int p = 0; p < PORTS; p++)
            for (int r = 0; r < 3; r++) begin
                rd(reg_addr(r, p), v);
                check(req, v, {24'h0, m_reg[p][r]});
            end
        check_pads(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  a, b, oldv;
        model_clear();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all("R1 reset");

        // R2 and R9: plain writes replace whole register, other ports untouched
        for (int p = 0; p < PORTS; p++)
            for (int r = 0; r < 3; r++) begin
                a = 8'(p * 61 + r * 23 + 8'h9C);
                wr(reg_addr(r, p), {16'hFFFF, 8'h33, a});
                m_reg[p][r] = a;
                rd(reg_addr(r, p), v);
                check("R2 plain write", v, {24'h0, a});
            end
        check_all("R9 port isolation");

        // R3, R4, R9: exhaustive select byte for each register of each port
        for (int p = 0; p < PORTS; p++)
            for (int r = 0; r < 3; r++)
                for (int m = 0; m < 256; m++) begin
                    a = 8'(m * 37 + p * 11 + r);
                    b = 8'(m) ^ 8'h5A ^ 8'(r * 3);
                    wr(reg_addr(r, p), {24'h0, a});
                    m_reg[p][r] = a;
                    wr(UOFF + reg_addr(r, p), {16'h0, 8'(m), b});
                    m_reg[p][r] = (a & ~8'(m)) | (b & 8'(m));
                    rd(reg_addr(r, p), v);
                    check("R3 masked write", v, {24'h0, m_reg[p][r]});
                    check_pads("R4 pad drive");
                    if ((m % 64) == 0) check_all("R9 port isolation sweep");
                end

        // R4: full pad map sweep on port 2
        for (int c = 0; c < 16; c++) begin
            a = 8'(c * 17);
            b = 8'(c * 29 + 3);
            wr(reg_addr(0, 2), {24'h0, a});  m_reg[2][0] = a;
            wr(reg_addr(1, 2), {24'h0, b});  m_reg[2][1] = b;
            wr(reg_addr(2, 2), {24'h0, ~a}); m_reg[2][2] = ~a;
            check_pads("R4 pad map");
        end

        // R5: two-stage input synchronizer, each port
        for (int p = 0; p < PORTS; p++) begin
            @(negedge clk);
            oldv = pad_in[p*8 +: 8];
            a = 8'(p * 53 + 8'hA5);
            pad_in[p*8 +: 8] = a;
            bus_addr = AW'(reg_addr(3, p));
            @(posedge clk);
            @(negedge clk);
            check("R5 input after one edge", bus_rdata, {24'h0, oldv});
            @(posedge clk);
            @(negedge clk);
            check("R5 input after two edges", bus_rdata, {24'h0, a});
        end

        // R6: writes to input address (plain and alias) are ignored
        for (int p = 0; p < PORTS; p++) begin
            wr(reg_addr(3, p), 32'h0000FFFF);
            wr(UOFF + reg_addr(3, p), 32'h0000FF00);
            rd(reg_addr(3, p), v);
            check("R6 input readback", v, {24'h0, pad_in[p*8 +: 8]});
        end
        check_all("R6 no state change");

        // R7: interrupt groups forwarded
        for (int o = 'h40; o < 'h80; o += 4) begin
            irq_rdata = 32'hC0DE0000 | 32'(o);
            rd(o, v);
            check("R7 irq_sel plain", 32'(irq_sel), 32'd1);
            check("R7 irq read plain", v, irq_rdata);
            if (o < 'h70) begin
                rd(UOFF + o, v);
                check("R7 irq_sel alias", 32'(irq_sel), 32'd1);
                check("R7 irq read alias", v, irq_rdata);
            end else begin
                rd(UOFF + o, v);
                check("R7 clear alias unmapped sel", 32'(irq_sel), 32'd0);
                check("R7 clear alias unmapped read", v, 32'd0);
            end
            wr(o, 32'hFFFFFFFF);
            wr(UOFF + o, 32'hFFFFFFFF);
        end
        check_all("R7 no local effect");

        // R8: unmapped addresses
        for (int k = 0; k < 6; k++) begin
            int ua;
            case (k)
                0: ua = 'h080;
                1: ua = 'h100;
                2: ua = 'h400;
                3: ua = 'h880;
                4: ua = 'hF00;
                default: ua = 'hFFC;
            endcase
            irq_rdata = 32'hDEADBEEF;
            rd(ua, v);
            check("R8 unmapped read", v, 32'd0);
            check("R8 unmapped irq_sel", 32'(irq_sel), 32'd0);
            wr(ua, 32'hFFFFFFFF);
        end
        check_all("R8 writes ignored");

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        check_all("R1 mid-run reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule